// File: doc/BRIEF.md
# Four-Byte Serial Frame Multiplexer with Confirmed Command Field

This block converts one four-byte time-division channel between a serial line and parallel registers. Each frame repeats at 8 kHz. The channel occupies the first 32 data bits of the frame. Each data bit lasts two bit-clock cycles, and the block's clock is that bit clock. The fields go out in this order: two bearer bytes, a management byte, then a signalling byte. The signalling byte holds a 2-bit D field, a 4-bit command/indication (C/I) code, an acknowledge bit and an end bit.

The block can act as frame master. In that mode it generates the frame sync and a secondary sync that marks the signalling byte. It can also act as slave, in which case it aligns to an incoming sync. On transmit, the parallel inputs are captured at each frame start, so the local indication code goes out in every frame. On receive, every field is latched at the end of the signalling byte and a one-cycle done strobe is raised. A received C/I code reaches the command output only after it has arrived unchanged in two consecutive frames.

Top module: `gci_framer`

## Requirements
- R1: With `master`=1, `fs_out` is high for exactly 16 clocks at the start of each frame, and the frame period is FRAME_CLKS clocks (default 512).
- R2: With `master`=1, `fsb_out` is high during frame positions 48 to 63 (16 clocks, the signalling byte). With `master`=0, both `fs_out` and `fsb_out` stay low.
- R3: With `master`=0, the clock edge at which `fs_in` is first sampled high after being low starts frame position 0. Position p occupies the clock cycle that follows p further edges.
- R4: `dout` sends 32 bits MSB first, each held for 2 clocks over positions 0 to 63, as the word {tx_b1, tx_b2, tx_mon, tx_d[1:0], tx_ci[3:0], tx_a, tx_e}. Outside that window `dout` is 1.
- R5: The transmit inputs are captured at the edge that starts a frame. Changes made during a frame do not alter the bits sent in that frame.
- R6: `din` is sampled at the edge that ends the second clock of each bit. After the final bit, `rx_b1`, `rx_b2`, `rx_mon`, `rx_d`, `rx_a` and `rx_e` hold the received fields, with the same layout as R4. `frame_done` is high for exactly that one cycle.
- R7: The received C/I code is bits 5:2 of the signalling byte. `ci_cmd` takes a code only when the same code has arrived in two consecutive frames and differs from the current `ci_cmd`. In that case `ci_chg` pulses in the same cycle as `frame_done`. A code seen in only one frame leaves `ci_cmd` unchanged.
- R8: When a confirmed code that is already in `ci_cmd` keeps arriving, `ci_chg` stays low.
- R9: After reset, `ci_cmd`, `frame_done`, `ci_chg` and all rx outputs are 0, and `dout` is 1 for the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per data bit |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1 = generate frame sync, 0 = follow fs_in |
| fs_in | input | 1 | Incoming frame sync (slave mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| fsb_out | output | 1 | Secondary sync marking the signalling byte (master mode) |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| tx_b1 | input | 8 | First bearer byte to send |
| tx_b2 | input | 8 | Second bearer byte to send |
| tx_mon | input | 8 | Management byte to send |
| tx_d | input | 2 | D field to send |
| tx_ci | input | 4 | Local indication code |
| tx_a | input | 1 | Acknowledge bit to send |
| tx_e | input | 1 | End bit to send |
| rx_b1 | output | 8 | Received first bearer byte |
| rx_b2 | output | 8 | Received second bearer byte |
| rx_mon | output | 8 | Received management byte |
| rx_d | output | 2 | Received D field |
| rx_a | output | 1 | Received acknowledge bit |
| rx_e | output | 1 | Received end bit |
| frame_done | output | 1 | One-cycle strobe after the signalling byte |
| ci_cmd | output | 4 | Confirmed command code |
| ci_chg | output | 1 | One-cycle strobe when ci_cmd changes |

## Verification
The bench targets the C/I filter with three patterns: a single-frame glitch, two different codes in a row, and a confirmed code that keeps repeating. A filter that accepted the first frame would let the glitch through. One that compared against the stored command, not the previous frame, would accept an alternating pair. One that strobed on every match would raise `ci_chg` on each repeat. The bench also changes the transmit inputs in the middle of a frame, which catches a design that does not capture them once per frame. In slave mode it checks the position of every transmitted bit, so an off-by-one in sync alignment or in the sampling phase shows up as a bit or byte shift. In master mode it measures the sync width, the secondary-sync position and the frame period clock by clock.

// File: rtl/gci_framer.sv
module gci_framer #(
  parameter int FRAME_CLKS = 512,
  parameter int SYNC_CLKS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master,
  input  logic       fs_in,
  output logic       fs_out,
  output logic       fsb_out,
  input  logic       din,
  output logic       dout,
  input  logic [7:0] tx_b1,
  input  logic [7:0] tx_b2,
  input  logic [7:0] tx_mon,
  input  logic [1:0] tx_d,
  input  logic [3:0] tx_ci,
  input  logic       tx_a,
  input  logic       tx_e,
  output logic [7:0] rx_b1,
  output logic [7:0] rx_b2,
  output logic [7:0] rx_mon,
  output logic [1:0] rx_d,
  output logic       rx_a,
  output logic       rx_e,
  output logic       frame_done,
  output logic [3:0] ci_cmd,
  output logic       ci_chg
);
  localparam int PW = $clog2(FRAME_CLKS);
  localparam logic [PW-1:0] LAST   = PW'(FRAME_CLKS - 1);
  localparam logic [PW-1:0] WIN    = PW'(64);
  localparam logic [PW-1:0] SIGLO  = PW'(48);
  localparam logic [PW-1:0] SYNCW  = PW'(SYNC_CLKS);
  localparam logic [PW-1:0] RXLAST = PW'(63);

  logic [PW-1:0] pos, pos_nx;
  logic          fs_q;
  logic [31:0]   tx_sh, rx_sh;
  logic [3:0]    ci_prev;
  logic          prev_vld;

  wire        rise   = fs_in & ~fs_q;
  wire        start  = master ? (pos == LAST) : (rise | pos == LAST);
  wire        active = pos < WIN;
  wire [4:0]  bidx   = pos[5:1];
  wire        rx_smp = active & pos[0];
  wire        rx_end = pos == RXLAST;
  wire [31:0] word   = {rx_sh[30:0], din};
  wire [3:0]  ci_new = word[5:2];

  assign pos_nx  = start ? '0 : pos + 1'b1;
  assign dout    = active ? tx_sh[~bidx] : 1'b1;
  assign fs_out  = master & (pos < SYNCW);
  assign fsb_out = master & (pos >= SIGLO) & active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos        <= '0;
      fs_q       <= 1'b0;
      tx_sh      <= '1;
      rx_sh      <= '0;
      rx_b1      <= '0;
      rx_b2      <= '0;
      rx_mon     <= '0;
      rx_d       <= '0;
      rx_a       <= 1'b0;
      rx_e       <= 1'b0;
      frame_done <= 1'b0;
      ci_cmd     <= '0;
      ci_chg     <= 1'b0;
      ci_prev    <= '0;
      prev_vld   <= 1'b0;
    end else begin
      pos        <= pos_nx;
      fs_q       <= fs_in;
      frame_done <= 1'b0;
      ci_chg     <= 1'b0;
      if (start)
        tx_sh <= {tx_b1, tx_b2, tx_mon, tx_d, tx_ci, tx_a, tx_e};
      if (rx_smp)
        rx_sh <= word;
      if (rx_smp && rx_end) begin
        rx_b1      <= word[31:24];
        rx_b2      <= word[23:16];
        rx_mon     <= word[15:8];
        rx_d       <= word[7:6];
        rx_a       <= word[1];
        rx_e       <= word[0];
        frame_done <= 1'b1;
        ci_prev    <= ci_new;
        prev_vld   <= 1'b1;
        if (prev_vld && ci_new == ci_prev && ci_new != ci_cmd) begin
          ci_cmd <= ci_new;
          ci_chg <= 1'b1;
        end
      end
    end
  end
endmodule

module gci_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master,
  input logic       fs_out,
  input logic       fsb_out,
  input logic       frame_done,
  input logic [3:0] ci_cmd,
  input logic       ci_chg,
  input logic [7:0] rx_b1
);
  // R2
  slave_sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !fs_out && !fsb_out);
  // R2
  sync_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_out && fsb_out));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(rx_b1));
  // R7
  chg_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ci_chg |-> frame_done);
  // R7
  cmd_moves_with_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ci_cmd) |-> ci_chg);
  // R8
  chg_means_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ci_chg |-> ci_cmd != $past(ci_cmd));
endmodule

bind gci_framer gci_framer_chk u_chk (.*);

// File: tb/gci_framer_bench.sv
module gci_framer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b0;
  logic fs_in = 1'b0;
  logic drv = 1'b1;
  logic lb = 1'b0;
  logic [31:0] txv = '1;
  logic fs_out, fsb_out, dout, din;
  logic [7:0] rx_b1, rx_b2, rx_mon;
  logic [1:0] rx_d;
  logic rx_a, rx_e, frame_done, ci_chg;
  logic [3:0] ci_cmd;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  assign din = lb ? dout : drv;

  gci_framer u_gci_framer (
    .clk(clk), .rst_n(rst_n), .master(master), .fs_in(fs_in),
    .fs_out(fs_out), .fsb_out(fsb_out), .din(din), .dout(dout),
    .tx_b1(txv[31:24]), .tx_b2(txv[23:16]), .tx_mon(txv[15:8]),
    .tx_d(txv[7:6]), .tx_ci(txv[5:2]), .tx_a(txv[1]), .tx_e(txv[0]),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon), .rx_d(rx_d),
    .rx_a(rx_a), .rx_e(rx_e), .frame_done(frame_done),
    .ci_cmd(ci_cmd), .ci_chg(ci_chg)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rxword(input logic [3:0] ci);
    return {8'hA5, 8'h3C, 8'h81, 2'b10, ci, 1'b0, 1'b1};
  endfunction

  task automatic reset_state;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ci_cmd == 0 && frame_done == 0 && ci_chg == 0, "R9 ctrl", {ci_cmd, frame_done, ci_chg}, 0);
    check(rx_b1 == 0 && rx_b2 == 0 && rx_mon == 0 && rx_d == 0, "R9 rx", {rx_b1, rx_b2, rx_mon}, 0);
    check(dout == 1'b1, "R9 dout", dout, 1);
    check(fs_out == 0 && fsb_out == 0, "R2 slave syncs", {fs_out, fsb_out}, 0);
  endtask

  task automatic slave_frame(input logic [31:0] rxw, input logic [31:0] txw, input bit disturb,
                             input logic [3:0] exp_cmd, input bit exp_chg, input string req);
    int bad = -1;
    txv = txw;
    @(negedge clk);
    fs_in = 1'b1;
    drv = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (i == 2) fs_in = 1'b0;
      if (disturb && i == 20) txv = ~txw;
      drv = rxw[31 - i / 2];
      if (dout !== txw[31 - i / 2] && bad < 0) bad = i;
      @(posedge clk);
    end
    @(negedge clk);
    check(bad < 0, disturb ? "R5 tx capture" : "R3/R4 tx bits", bad, -1);
    check(frame_done == 1'b1, "R6 done", frame_done, 1);
    check({rx_b1, rx_b2, rx_mon, rx_d, rx_a, rx_e} == {rxw[31:6], rxw[1:0]}, "R6 rx fields",
          {rx_b1, rx_b2, rx_mon, rx_d, rx_a, rx_e}, {rxw[31:6], rxw[1:0]});
    check(ci_cmd == exp_cmd && ci_chg == exp_chg, req, {ci_cmd, ci_chg}, {exp_cmd, exp_chg});
    check(dout == 1'b1, "R4 idle", dout, 1);
    @(negedge clk);
    check(frame_done == 1'b0 && ci_chg == 1'b0, "R6 pulse", {frame_done, ci_chg}, 0);
    drv = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ci_filter_seq;
    slave_frame(rxword(4'h5), 32'h12345678, 0, 4'h0, 0, "R7 first frame");
    slave_frame(rxword(4'h5), 32'hCAFE0F0D, 0, 4'h5, 1, "R7 confirm");
    slave_frame(rxword(4'h5), 32'h0000FFFF, 0, 4'h5, 0, "R8 repeat");
    slave_frame(rxword(4'h9), 32'hDEADBEEF, 1, 4'h5, 0, "R7 glitch");
    slave_frame(rxword(4'h3), 32'h80000001, 0, 4'h5, 0, "R7 differ");
    slave_frame(rxword(4'h3), 32'h5A5AA5A5, 0, 4'h3, 1, "R7 confirm2");
  endtask

  task automatic master_sync;
    int hi = 0, fsb_hi = 0, fsb_first = -1, period = -1, n = 0;
    master = 1'b1;
    while (!(fs_out == 0) && n < 2000) begin @(negedge clk); n++; end
    while (!(fs_out == 1) && n < 2000) begin @(negedge clk); n++; end
    for (int k = 0; k < 1024; k++) begin
      if (fs_out && k < 100) hi++;
      if (fsb_out && k < 512) begin
        fsb_hi++;
        if (fsb_first < 0) fsb_first = k;
      end
      @(negedge clk);
      if (period < 0 && fs_out && k > 20) period = k + 1;
    end
    check(hi == 16, "R1 sync width", hi, 16);
    check(period == 512, "R1 period", period, 512);
    check(fsb_hi == 16 && fsb_first == 48, "R2 fsb window", {fsb_hi, fsb_first}, {32'd16, 32'd48});
  endtask

  task automatic master_loop;
    int n = 0;
    lb = 1'b1;
    txv = {8'h77, 8'h18, 8'hE4, 2'b01, 4'hA, 1'b1, 1'b0};
    while (n < 3) begin @(negedge clk); if (frame_done) n++; end
    check(ci_cmd == 4'hA, "R7 master loopback", ci_cmd, 4'hA);
    check(rx_b1 == 8'h77 && rx_mon == 8'hE4 && rx_d == 2'b01 && rx_a == 1 && rx_e == 0,
          "R6 loopback fields", {rx_b1, rx_mon}, 16'h77E4);
    lb = 1'b0;
    master = 1'b0;
  endtask

  initial begin
    reset_state();
    ci_filter_seq();
    master_sync();
    master_loop();
    @(negedge clk);
    check(fs_out == 0 && fsb_out == 0, "R2 back to slave", {fs_out, fsb_out}, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule